// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter

A presettable binary counter that steps up or down by one on each rising clock edge and can be chained into wider counters with no glue logic. A parallel word is loaded synchronously through an active-low load input that takes priority over counting. A direction input selects increment or decrement.

Counting is gated by two active-low enables. `cnt_en_n` stops only this stage. `chain_en_n` stops this stage and also masks the active-low terminal-count output `tc_n`. `tc_n` is decoded from the held count, the direction and `chain_en_n` only. It reads all-ones when counting up and all-zeros when counting down. Wiring each stage's `tc_n` to the next stage's `chain_en_n`, with a shared clock, load, direction and `cnt_en_n`, builds a fully synchronous counter that is a multiple of `WIDTH` bits wide. There is no reset. A synchronous load sets the initial value.

Top module: `updn_cascade_counter`

## Requirements
- R1: At a rising edge with `ld_n` low, `cnt` takes `din`, whatever the levels of `cnt_en_n`, `chain_en_n` and `up`.
- R2: At a rising edge with `ld_n` high, both enables low and `up` high, `cnt` increments by one and wraps from all-ones to zero.
- R3: At a rising edge with `ld_n` high, both enables low and `up` low, `cnt` decrements by one and wraps from zero to all-ones.
- R4: At a rising edge with `ld_n` high and either enable high, `cnt` keeps its value.
- R5: With `up` high, `tc_n` is low exactly when `chain_en_n` is low and `cnt` is all-ones.
- R6: With `up` low, `tc_n` is low exactly when `chain_en_n` is low and `cnt` is all-zeros.
- R7: `tc_n` is high whenever `chain_en_n` is high, and `cnt_en_n` has no effect on `tc_n`.
- R8: Changes on `ld_n`, `up`, `din` or either enable between rising edges leave `cnt` unchanged until the next rising edge.
- R9: Stages chained `tc_n` to `chain_en_n` count as one synchronous counter of the combined width, with the first stage as the least significant, in both directions and across the full wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| din | input | WIDTH | Parallel preset value |
| ld_n | input | 1 | Active-low synchronous load |
| up | input | 1 | 1 = count up, 0 = count down |
| cnt_en_n | input | 1 | Active-low local count enable |
| chain_en_n | input | 1 | Active-low chain enable; also gates `tc_n` |
| cnt | output | WIDTH | Current count |
| tc_n | output | 1 | Active-low terminal-count / carry to next stage |

## Verification
The bench checks load priority by loading while the enables and direction are at their counting levels. A design that let counting win would come out off by one. It drives both wraps in each direction. A counter that saturated, or that decoded the terminal value without looking at direction, would either stall or raise `tc_n` at the wrong end. It holds the count at terminal with only `cnt_en_n` high, where `tc_n` must stay low, and with only `chain_en_n` high, where `tc_n` must go high. This separates the two enables, which a design could easily swap. A three-stage chain is run through the 12-bit rollover both ways, so a carry decoded one count early or late shows up as a wrong upper nibble.

// File: rtl/updn_cascade_counter.sv
module updn_cascade_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din,
  input  logic             ld_n,
  input  logic             up,
  input  logic             cnt_en_n,
  input  logic             chain_en_n,
  output logic [WIDTH-1:0] cnt,
  output logic             tc_n
);
  localparam logic [WIDTH-1:0] TOP = '1;
  localparam logic [WIDTH-1:0] BOT = '0;
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic             run;
  logic [WIDTH-1:0] stepped;
  logic [WIDTH-1:0] nxt;
  logic             at_term;

  assign run     = ~cnt_en_n & ~chain_en_n;
  assign stepped = up ? cnt + ONE : cnt - ONE;
  assign nxt     = ~ld_n ? din : (run ? stepped : cnt);
  assign at_term = up ? (cnt == TOP) : (cnt == BOT);
  assign tc_n    = ~(~chain_en_n & at_term);

  always_ff @(posedge clk)
    cnt <= nxt;
endmodule

// File: rtl/updn_cascade_counter_chk.sv
module updn_cascade_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic [WIDTH-1:0] din,
  input logic             ld_n,
  input logic             up,
  input logic             cnt_en_n,
  input logic             chain_en_n,
  input logic [WIDTH-1:0] cnt,
  input logic             tc_n
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
  logic armed = 1'b0;

  always_ff @(posedge clk)
    if (!ld_n) armed <= 1'b1;

  p_load_r1: assert property (@(posedge clk) disable iff (!armed)
    !$past(ld_n) |-> cnt == $past(din));

  p_inc_r2: assert property (@(posedge clk) disable iff (!armed)
    ($past(ld_n) && !$past(cnt_en_n) && !$past(chain_en_n) && $past(up))
      |-> cnt == $past(cnt) + ONE);

  p_dec_r3: assert property (@(posedge clk) disable iff (!armed)
    ($past(ld_n) && !$past(cnt_en_n) && !$past(chain_en_n) && !$past(up))
      |-> cnt == $past(cnt) - ONE);

  p_hold_r4: assert property (@(posedge clk) disable iff (!armed)
    ($past(ld_n) && ($past(cnt_en_n) || $past(chain_en_n))) |-> $stable(cnt));

  p_top_r5: assert property (@(posedge clk) disable iff (!armed)
    (!chain_en_n && up && (&cnt)) |-> !tc_n);

  p_bot_r6: assert property (@(posedge clk) disable iff (!armed)
    (!chain_en_n && !up && !(|cnt)) |-> !tc_n);

  p_mask_r7: assert property (@(posedge clk) disable iff (!armed)
    chain_en_n |-> tc_n);
endmodule

bind updn_cascade_counter updn_cascade_counter_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/updn_cascade_counter_tb_top.sv
module updn_cascade_counter_tb_top;
  localparam int W = 4;
  localparam int NS = 3;
  localparam int CW = W * NS;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] din = '0;
  logic ld_n = 1'b1, up = 1'b1, pe_n = 1'b1, te_n = 1'b1, cte_n = 1'b1;
  logic [W-1:0] cnt;
  logic tc_n;

  updn_cascade_counter #(.WIDTH(W)) dut_i (
    .clk(clk), .din(din), .ld_n(ld_n), .up(up), .cnt_en_n(pe_n),
    .chain_en_n(te_n), .cnt(cnt), .tc_n(tc_n));

  logic [NS:0] chain;
  logic [CW-1:0] ccnt;
  assign chain[0] = cte_n;
  for (genvar i = 0; i < NS; i++) begin : g_stage
    updn_cascade_counter #(.WIDTH(W)) st_i (
      .clk(clk), .din(din), .ld_n(ld_n), .up(up), .cnt_en_n(pe_n),
      .chain_en_n(chain[i]), .cnt(ccnt[i*W +: W]), .tc_n(chain[i+1]));
  end

  int checks = 0, errors = 0;
  int m = 0, cm = 0;
  bit valid = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_tc(input int v, input int mx, input logic t, input logic u);
    return (!t && ((u && v == mx) || (!u && v == 0))) ? 0 : 1;
  endfunction

  task automatic step(input logic l, input logic [W-1:0] d, input logic u,
                      input logic p, input logic t, input logic ct);
    ld_n = l; din = d; up = u; pe_n = p; te_n = t; cte_n = ct;
    #1;
    if (valid) begin
      chk(cnt == m[W-1:0], "R8 single", int'(cnt), m);
      chk(ccnt == cm[CW-1:0], "R8 chain", int'(ccnt), cm);
      chk(tc_n == exp_tc(m, 15, t, u), u ? "R5/R7 tc" : "R6/R7 tc", int'(tc_n), exp_tc(m, 15, t, u));
      chk(chain[NS] == exp_tc(cm, (1 << CW) - 1, ct, u), "R9 chain tc", int'(chain[NS]),
          exp_tc(cm, (1 << CW) - 1, ct, u));
    end
    @(posedge clk);
    if (!l) begin
      m = int'(d); cm = int'({NS{d}}); valid = 1;
    end else begin
      if (!p && !t) m = u ? (m + 1) % 16 : (m + 15) % 16;
      if (!p && !ct) cm = u ? (cm + 1) % (1 << CW) : (cm + (1 << CW) - 1) % (1 << CW);
    end
    #2;
    chk(cnt == m[W-1:0], !l ? "R1 load" : (p | t) ? "R4 hold" : u ? "R2 up" : "R3 down",
        int'(cnt), m);
    chk(ccnt == cm[CW-1:0], "R9 chain count", int'(ccnt), cm);
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(0, 4'hD, 1, 0, 0, 0);
    step(0, 4'hD, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) step(1, 4'h3, 1, 0, 0, 0);
    for (int i = 0; i < 6; i++) step(1, 4'h7, 0, 0, 0, 0);
    step(1, 4'h0, 0, 1, 0, 1);
    step(1, 4'h0, 1, 0, 1, 1);
    step(0, 4'hF, 1, 1, 1, 1);
    step(1, 4'h0, 1, 1, 0, 0);
    step(1, 4'h0, 1, 0, 1, 1);
    step(1, 4'h0, 1, 0, 0, 0);
    step(1, 4'h0, 0, 1, 0, 1);
    step(0, 4'h0, 0, 1, 1, 1);
    step(1, 4'h0, 0, 1, 0, 0);
    step(1, 4'h0, 0, 0, 0, 0);
    step(1, 4'h0, 1, 0, 0, 0);
    for (int i = 0; i < 300; i++) step(1, 4'h0, 1, (i % 7) == 3, 0, (i % 11) == 5);
    step(0, 4'hF, 1, 0, 0, 0);
    for (int i = 0; i < 20; i++) step(1, 4'h0, (i < 10) ? 1'b0 : 1'b1, 0, 0, 0);
    step(0, 4'h1, 0, 0, 0, 0);
    for (int i = 0; i < 40; i++) step(1, 4'h0, 0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule